// File: doc/BRIEF.md
# Broadcast-Capable Configuration Register Bus

This block carries register writes and reads from one controller to six identical register slaves over a shared parallel bus. A host raises a level request with a direction, a target index, a 12-bit address and 16 bits of write data. The request line is brought into the system clock domain and its rising edge launches one transfer. The controller then drives the shared address and data lines. It picks its target with a private write or read strobe per slave, so every slave decodes the same address map and none needs a hard-wired identity.

Target index 6 is a virtual slave: a write to it raises all six write strobes at once, so one transfer configures every slave. Each slave holds a register array. Each slave watches for writes to its converter-setting register at address 0x010 and emits a one-cycle update pulse with the new value, so a downstream converter loader can act at once. Reads give a fixed-latency readback path, so software can test the bus.

The controller state machine has four states. ST_IDLE waits for a launch. ST_ADDR presents the address and strobes. ST_WAIT lets the selected slave drive its registered data. ST_ACK shows the captured result with an acknowledge. The transitions are named as follows. T_START (ST_IDLE to ST_ADDR) fires on a synchronised request edge. T_WR_DONE (ST_ADDR to ST_ACK) applies to writes. T_RD_ISSUE (ST_ADDR to ST_WAIT) applies to reads. T_RD_CAPTURE (ST_WAIT to ST_ACK) follows it. T_RETIRE (ST_ACK to ST_IDLE) always follows ST_ACK.

Top module: `cfg_bus_top`

## Requirements
- R1: After reset, host_ack, host_err, host_rdata and dac_update are all zero, and every slave register reads as zero.
- R2: A write with host_sel 0 to 5 changes only the addressed register of that one slave.
- R3: A write with host_sel 6 stores the data at the addressed register of all six slaves.
- R4: A read with host_sel 0 to 5 returns the stored value with host_err 0; host_ack rises on the 5th falling clock edge after host_req rises on a falling edge, and host_rdata and host_err hold their values until the next acknowledge.
- R5: A write is acknowledged on the 4th falling clock edge after host_req rises on a falling edge.
- R6: A read with host_sel 6 or 7 returns 0xDEAD with host_err 1; the next legal transfer clears host_err.
- R7: A legal write to address 0x010 pulses dac_update for one cycle, in the acknowledge cycle, on the targeted slave (bit n for slave n, all six bits for index 6). The 16-bit slice n of dac_value (bits 16n+15 to 16n) carries the written value.
- R8: Writes to any other address, including ones whose low bits equal 0x010, give no dac_update pulse.
- R9: Addresses at or above the register depth (32) are compared on all 12 bits; writes to them are ignored and reads return 0.
- R10: Each rising request edge yields exactly one single-cycle acknowledge, even if host_req stays high.
- R11: A write with host_sel 7 changes no register, returns 0xDEAD and sets host_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_req | input | 1 | Asynchronous transfer request level |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_sel | input | 3 | Target slave index; 6 = broadcast |
| host_addr | input | 12 | Register address |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read result, held between acknowledges |
| host_ack | output | 1 | One-cycle transfer-complete pulse |
| host_err | output | 1 | Illegal target flag, held between acknowledges |
| dac_update | output | 6 | Per-slave converter-register write pulse |
| dac_value | output | 96 | Per-slave converter value, 16 bits each |

## Verification
The assertions assume that host_wr, host_sel, host_addr and host_wdata stay stable from the request's rising edge until the acknowledge. They also assume that host_req falls and stays low long enough for the synchroniser to see the low level before the next request. The bench keeps within this: it changes the fields only together with the request edge, holds them until the acknowledge, and leaves at least three idle cycles before each new transfer. A behavioural model of all six register arrays predicts the acknowledge, readback, error flag and update pulses on every falling edge.

// File: rtl/cfg_bus_pkg.sv
package cfg_bus_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ADDR,
        ST_WAIT,
        ST_ACK
    } cfg_state_e;

endpackage

// File: rtl/cfg_req_sync.sv
module cfg_req_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic req_async,
    output logic launch
);
    logic meta_q, sync_q, prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= req_async;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign launch = sync_q & ~prev_q;
endmodule

// File: rtl/cfg_master.sv
module cfg_master
    import cfg_bus_pkg::*;
#(
    parameter int          DATA_W   = 16,
    parameter int          ADDR_W   = 12,
    parameter int          NUM_SLV  = 6,
    parameter int          SEL_W    = 3,
    parameter logic [15:0] BAD_WORD = 16'hDEAD
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic              req_wr,
    input  logic [SEL_W-1:0]  req_sel,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic [NUM_SLV-1:0] bus_wr,
    output logic [NUM_SLV-1:0] bus_rd,
    input  logic [DATA_W-1:0] slv_rdata [NUM_SLV],
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_ack,
    output logic              host_err
);
    localparam logic [SEL_W-1:0] BCAST = SEL_W'(NUM_SLV);

    cfg_state_e state_q, state_d;

    logic              lat_wr;
    logic [SEL_W-1:0]  lat_sel;
    logic [ADDR_W-1:0] lat_addr;
    logic [DATA_W-1:0] lat_wdata;
    logic              unicast, rd_legal, wr_legal;

    assign unicast  = (lat_sel < BCAST);
    assign rd_legal = unicast;
    assign wr_legal = unicast || (lat_sel == BCAST);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (launch) state_d = ST_ADDR;           // T_START
            ST_ADDR: state_d = lat_wr ? ST_ACK : ST_WAIT;      // T_WR_DONE / T_RD_ISSUE
            ST_WAIT: state_d = ST_ACK;                         // T_RD_CAPTURE
            ST_ACK:  state_d = ST_IDLE;                        // T_RETIRE
        endcase
    end

    // outputs decoded from state
    always_comb begin
        bus_wr   = '0;
        bus_rd   = '0;
        host_ack = 1'b0;
        bus_addr = lat_addr;
        bus_wdata = lat_wdata;
        unique case (state_q)
            ST_ADDR: begin
                for (int i = 0; i < NUM_SLV; i++) begin
                    if (lat_wr && (lat_sel == BCAST || lat_sel == SEL_W'(i)))
                        bus_wr[i] = 1'b1;
                    if (!lat_wr && lat_sel == SEL_W'(i))
                        bus_rd[i] = 1'b1;
                end
            end
            ST_ACK:  host_ack = 1'b1;
            ST_IDLE, ST_WAIT: ;
        endcase
    end

    // request capture and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_wr     <= 1'b0;
            lat_sel    <= '0;
            lat_addr   <= '0;
            lat_wdata  <= '0;
            host_rdata <= '0;
            host_err   <= 1'b0;
        end else begin
            if (state_q == ST_IDLE && launch) begin
                lat_wr    <= req_wr;
                lat_sel   <= req_sel;
                lat_addr  <= req_addr;
                lat_wdata <= req_wdata;
            end
            if (state_q == ST_ADDR && lat_wr) begin
                host_err <= !wr_legal;
                if (!wr_legal) host_rdata <= BAD_WORD;
            end
            if (state_q == ST_WAIT) begin
                host_err   <= !rd_legal;
                host_rdata <= rd_legal ? slv_rdata[lat_sel] : BAD_WORD;
            end
        end
    end
endmodule

// File: rtl/cfg_slave.sv
module cfg_slave #(
    parameter int                DATA_W    = 16,
    parameter int                ADDR_W    = 12,
    parameter int                REG_DEPTH = 32,
    parameter logic [ADDR_W-1:0] DAC_ADDR  = 12'h010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              dac_update,
    output logic [DATA_W-1:0] dac_value
);
    localparam int IDX_W = $clog2(REG_DEPTH);

    logic [DATA_W-1:0] regs [REG_DEPTH];
    logic              in_range;
    logic [IDX_W-1:0]  idx;

    assign in_range = (int'(addr) < REG_DEPTH);
    assign idx      = addr[IDX_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < REG_DEPTH; i++) regs[i] <= '0;
            rdata      <= '0;
            dac_update <= 1'b0;
            dac_value  <= '0;
        end else begin
            dac_update <= 1'b0;
            if (wr && in_range) regs[idx] <= wdata;
            if (wr && addr == DAC_ADDR) begin
                dac_update <= 1'b1;
                dac_value  <= wdata;
            end
            if (rd) rdata <= in_range ? regs[idx] : '0;
        end
    end
endmodule

// File: rtl/cfg_bus_top.sv
module cfg_bus_top #(
    parameter int          DATA_W    = 16,
    parameter int          ADDR_W    = 12,
    parameter int          NUM_SLV   = 6,
    parameter int          REG_DEPTH = 32,
    parameter int          DAC_ADDR  = 16,
    parameter logic [15:0] BAD_WORD  = 16'hDEAD,
    localparam int         SEL_W     = $clog2(NUM_SLV + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      host_req,
    input  logic                      host_wr,
    input  logic [SEL_W-1:0]          host_sel,
    input  logic [ADDR_W-1:0]         host_addr,
    input  logic [DATA_W-1:0]         host_wdata,
    output logic [DATA_W-1:0]         host_rdata,
    output logic                      host_ack,
    output logic                      host_err,
    output logic [NUM_SLV-1:0]        dac_update,
    output logic [NUM_SLV*DATA_W-1:0] dac_value
);
    logic              launch;
    logic [ADDR_W-1:0] bus_addr;
    logic [DATA_W-1:0] bus_wdata;
    logic [NUM_SLV-1:0] bus_wr, bus_rd;
    logic [DATA_W-1:0] slv_rdata [NUM_SLV];

    cfg_req_sync u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_async (host_req),
        .launch    (launch)
    );

    cfg_master #(
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W),
        .NUM_SLV  (NUM_SLV),
        .SEL_W    (SEL_W),
        .BAD_WORD (BAD_WORD)
    ) u_master (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch     (launch),
        .req_wr     (host_wr),
        .req_sel    (host_sel),
        .req_addr   (host_addr),
        .req_wdata  (host_wdata),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .slv_rdata  (slv_rdata),
        .host_rdata (host_rdata),
        .host_ack   (host_ack),
        .host_err   (host_err)
    );

    for (genvar g = 0; g < NUM_SLV; g++) begin : g_slv
        cfg_slave #(
            .DATA_W    (DATA_W),
            .ADDR_W    (ADDR_W),
            .REG_DEPTH (REG_DEPTH),
            .DAC_ADDR  (ADDR_W'(DAC_ADDR))
        ) u_slave (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr         (bus_wr[g]),
            .rd         (bus_rd[g]),
            .addr       (bus_addr),
            .wdata      (bus_wdata),
            .rdata      (slv_rdata[g]),
            .dac_update (dac_update[g]),
            .dac_value  (dac_value[g*DATA_W +: DATA_W])
        );
    end
endmodule

// File: rtl/cfg_bus_chk.sv
module cfg_bus_chk #(
    parameter int          DATA_W   = 16,
    parameter int          NUM_SLV  = 6,
    parameter logic [15:0] BAD_WORD = 16'hDEAD
) (
    input logic               clk,
    input logic               rst_n,
    input logic               host_ack,
    input logic               host_err,
    input logic [DATA_W-1:0]  host_rdata,
    input logic [NUM_SLV-1:0] dac_update,
    input logic [NUM_SLV-1:0] bus_wr
);
    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |=> !host_ack);                                            // R10
    AST_ERR_DEAD: assert property (@(posedge clk) disable iff (!rst_n)
        (host_ack && host_err) |-> host_rdata == DATA_W'(BAD_WORD));         // R6
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !host_ack |-> ($stable(host_rdata) && $stable(host_err)));          // R4
    AST_DAC_IN_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (|dac_update) |-> host_ack);                                        // R7
    AST_DAC_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        (|dac_update) |-> ($countones(dac_update) == 1 || &dac_update));    // R3
    AST_STROBE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(bus_wr) <= 1) || (&bus_wr));                            // R2
    AST_WR_ACK_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (|bus_wr) |=> host_ack);                                            // R5
endmodule

bind cfg_bus_top cfg_bus_chk #(
    .DATA_W   (DATA_W),
    .NUM_SLV  (NUM_SLV),
    .BAD_WORD (BAD_WORD)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_ack   (host_ack),
    .host_err   (host_err),
    .host_rdata (host_rdata),
    .dac_update (dac_update),
    .bus_wr     (bus_wr)
);

// File: tb/cfg_bus_top_test.sv
`timescale 1ns/1ps
module cfg_bus_top_test;
    localparam time CLK_PERIOD = 80ns;
    localparam int  NS = 6;
    localparam int  DEPTH = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0;
    logic        host_wr = 1'b0;
    logic [2:0]  host_sel = '0;
    logic [11:0] host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        host_ack, host_err;
    logic [5:0]  dac_update;
    logic [95:0] dac_value;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    int          mem [NS][DEPTH];
    logic [15:0] e_rdata = '0;
    logic        e_err   = 1'b0;

    cfg_bus_top uut (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_wr(host_wr),
        .host_sel(host_sel), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .host_ack(host_ack), .host_err(host_err),
        .dac_update(dac_update), .dac_value(dac_value)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_checks++; n_fail++;
            $display("FAIL R10 watchdog: actual hung run, expected completion");
            finish_run();
        end
    end

    task automatic chk(input string r, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", r, what, act, exp);
        end
    endtask

    // one falling edge, compare every output against the model
    task automatic tick(input string r, input logic e_ack, input logic [5:0] e_mask, input logic [15:0] e_dv);
        @(negedge clk);
        chk(r, "host_ack",   32'(host_ack),   32'(e_ack));
        chk(r, "host_rdata", 32'(host_rdata), 32'(e_rdata));
        chk(r, "host_err",   32'(host_err),   32'(e_err));
        chk(r, "dac_update", 32'(dac_update), 32'(e_mask));
        for (int i = 0; i < NS; i++)
            if (e_mask[i]) chk(r, "dac_value", 32'(dac_value[i*16 +: 16]), 32'(e_dv));
    endtask

    task automatic txn(input string r, input logic wr, input int sel, input int addr,
                       input logic [15:0] data, input int hold = 0);
        int lat;
        logic [5:0] mask;
        mask = '0;
        lat  = wr ? 4 : 5;
        host_wr = wr; host_sel = 3'(sel); host_addr = 12'(addr); host_wdata = data;
        host_req = 1'b1;
        for (int k = 1; k <= lat; k++) begin
            if (k == lat) begin
                if (wr) begin
                    if (sel <= NS) begin
                        e_err = 1'b0;
                        for (int s = 0; s < NS; s++)
                            if (sel == NS || sel == s) begin
                                if (addr < DEPTH) mem[s][addr] = int'(data);
                                if (addr == 16) mask[s] = 1'b1;
                            end
                    end else begin
                        e_err = 1'b1; e_rdata = 16'hDEAD;
                    end
                end else begin
                    if (sel < NS) begin
                        e_err = 1'b0;
                        e_rdata = (addr < DEPTH) ? 16'(mem[sel][addr]) : 16'h0;
                    end else begin
                        e_err = 1'b1; e_rdata = 16'hDEAD;
                    end
                end
                tick(r, 1'b1, mask, data);
            end else begin
                tick(r, 1'b0, '0, '0);
            end
        end
        for (int k = 0; k < hold; k++) tick("R10", 1'b0, '0, '0);
        host_req = 1'b0;
        for (int k = 0; k < 3; k++) tick(r, 1'b0, '0, '0);
    endtask

    initial begin
        for (int s = 0; s < NS; s++)
            for (int a = 0; a < DEPTH; a++) mem[s][a] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < 3; k++) tick("R1", 1'b0, '0, '0);
        txn("R1", 1'b0, 2, 5, '0);

        // single-slave writes and isolation
        txn("R5", 1'b1, 0, 1, 16'h1111);
        txn("R5", 1'b1, 5, 31, 16'h5555);
        txn("R7", 1'b1, 3, 16, 16'hABCD);
        txn("R8", 1'b1, 1, 15, 16'h0123);
        txn("R4", 1'b0, 0, 1, '0);
        txn("R4", 1'b0, 5, 31, '0);
        txn("R4", 1'b0, 3, 16, '0);
        txn("R2", 1'b0, 1, 1, '0);
        txn("R2", 1'b0, 4, 16, '0);

        // broadcast
        txn("R3", 1'b1, 6, 2, 16'hBEEF);
        for (int s = 0; s < NS; s++) txn("R3", 1'b0, s, 2, '0);
        txn("R7", 1'b1, 6, 16, 16'h7777);
        for (int s = 0; s < NS; s++) txn("R7", 1'b0, s, 16, '0);

        // illegal targets
        txn("R6", 1'b0, 6, 2, '0);
        txn("R6", 1'b0, 0, 1, '0);
        txn("R6", 1'b0, 7, 2, '0);
        txn("R11", 1'b1, 7, 2, 16'h0000);
        txn("R11", 1'b0, 0, 2, '0);

        // out-of-range addresses, full-width compare
        txn("R9", 1'b1, 4, 12'h020, 16'h9999);
        txn("R9", 1'b0, 4, 0, '0);
        txn("R9", 1'b0, 4, 12'h020, '0);
        txn("R8", 1'b1, 2, 12'h810, 16'h4242);
        txn("R9", 1'b0, 2, 16, '0);

        // held request gives one acknowledge
        txn("R10", 1'b0, 5, 31, '0, 8);

        // sweep of patterns
        for (int s = 0; s < NS; s++) txn("R2", 1'b1, s, 3 + s, 16'(16'h1000 * (s + 1) + s));
        for (int s = 0; s < NS; s++) txn("R2", 1'b0, s, 3 + s, '0);
        for (int s = 0; s < NS; s++) txn("R2", 1'b0, (s + 1) % NS, 3 + s, '0);

        finish_run();
    end
endmodule